// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

The block collects seven interrupt sources into a single flag register, masks them with an enable register, and drives one active-low interrupt request. Three sources arrive as one-cycle set pulses from neighbouring logic: timer 1, timer 2 and the shift register. The other four come from asynchronous control lines: two per port, a primary line and a secondary line. Each line passes through a synchronizer and an edge detector. A peripheral control byte sets the edge polarity of each line and, for the secondary lines, the operating mode.

A flag can be cleared in two ways. The CPU can write a one to it in the flag register. A neighbouring register access can also clear it, and the surrounding logic reports such an access as a one-cycle pulse on a dedicated input. A secondary line placed in independent mode ignores these port-access clears, so only an explicit flag write clears it. The enable register is written with a set/clear protocol in which bit 7 chooses the direction.

Top module: `intr_ctrl`

## Requirements
- R1: Flag register bit positions are: 6 timer 1, 5 timer 2, 4 port-B primary line, 3 port-B secondary line, 2 shift register, 1 port-A primary line, 0 port-A secondary line. Reading the flag register (reg_addr_i = 0) returns bit 7 as 1 exactly when some flag is set together with its enable bit.
- R2: A flag register write (reg_addr_i = 0, reg_we_i = 1) clears every flag whose data bit is 1 and leaves every flag whose data bit is 0 unchanged.
- R3: An enable register write (reg_addr_i = 1) with data bit 7 = 1 sets the enable bits selected by ones in bits 6..0. With data bit 7 = 0 it clears those bits. Enable bits whose mask bit is 0 keep their value. Reading the enable register returns bit 7 as 1 and bits 6..0 as the enables. All enables are 0 after reset.
- R4: irq_no is 0 whenever at least one flag and its enable bit are both 1, and 1 otherwise.
- R5: The primary lines detect a negative edge when their control bit is 0 and a positive edge when it is 1. The control bit is pcr_i[0] for port A and pcr_i[4] for port B.
- R6: The secondary line mode is a 3-bit code: pcr_i[3:1] for port A and pcr_i[7:5] for port B. Code 000 selects a negative edge, 001 an independent negative edge, 010 a positive edge and 011 an independent positive edge. Codes 1xx set no flag.
- R7: A pulse on ora_acc_i clears the port-A flags (bits 1 and 0), and a pulse on orb_acc_i clears the port-B flags (bits 4 and 3). sr_acc_i clears bit 2, t1_clr_i clears bit 6 and t2_clr_i clears bit 5.
- R8: A secondary line in an independent mode (001 or 011) keeps its flag through an access pulse on its port. Only a flag register write clears it.
- R9: When a flag is set and cleared in the same cycle, the set wins.
- R10: A line edge presented just before clock edge k appears in the flag register after clock edge k+2, and not before. A line level that is already present during reset sets no flag.
- R11: A pulse on t1_set_i, t2_set_i or sr_set_i sets the corresponding flag, and no flag becomes set without a set event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 1 | Register select: 0 flag, 1 enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| pcr_i | input | 8 | Line edge and mode control |
| ca1_i | input | 1 | Port-A primary line (asynchronous) |
| ca2_i | input | 1 | Port-A secondary line (asynchronous) |
| cb1_i | input | 1 | Port-B primary line (asynchronous) |
| cb2_i | input | 1 | Port-B secondary line (asynchronous) |
| t1_set_i | input | 1 | Timer 1 timeout pulse |
| t2_set_i | input | 1 | Timer 2 timeout pulse |
| sr_set_i | input | 1 | Shift register done pulse |
| t1_clr_i | input | 1 | Timer 1 flag clearing access pulse |
| t2_clr_i | input | 1 | Timer 2 flag clearing access pulse |
| sr_acc_i | input | 1 | Shift register access pulse |
| ora_acc_i | input | 1 | Port-A output register access pulse |
| orb_acc_i | input | 1 | Port-B output register access pulse |
| irq_no | output | 1 | Active-low interrupt request |

## Verification
The bench sweeps every polarity and every mode code on all four lines, driving both rising and falling transitions. A decoder that swapped polarity, or that let output-mode codes raise flags, would mark the wrong cases. It repeats the port-access clears with the secondary lines in ordinary mode and then in independent mode. A design that ignored independence would lose those flags, and one that applied it to the primary lines would keep theirs. It also checks the exact cycle in which a synchronized edge appears and holds a line high through reset; an edge detector with missing stages or a false start shows up there. A sweep of every flag against every single enable catches a mask applied to the wrong bit in the interrupt output or in read bit 7.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int unsigned NUM_SRC   = 7;
  localparam int unsigned NUM_LINES = 4;
  // flag bit positions, decoded by software
  localparam int unsigned BIT_CA2 = 0;
  localparam int unsigned BIT_CA1 = 1;
  localparam int unsigned BIT_SR  = 2;
  localparam int unsigned BIT_CB2 = 3;
  localparam int unsigned BIT_CB1 = 4;
  localparam int unsigned BIT_T2  = 5;
  localparam int unsigned BIT_T1  = 6;
  // line indices inside the edge detector array
  localparam int unsigned LN_CA1 = 0;
  localparam int unsigned LN_CA2 = 1;
  localparam int unsigned LN_CB1 = 2;
  localparam int unsigned LN_CB2 = 3;

  typedef struct packed {
    logic active;
    logic pos;
    logic indep;
  } line_cfg_t;

  function automatic line_cfg_t decode_primary(logic pol);
    line_cfg_t c;
    c.active = 1'b1;
    c.pos    = pol;
    c.indep  = 1'b0;
    return c;
  endfunction

  function automatic line_cfg_t decode_secondary(logic [2:0] mode);
    line_cfg_t c;
    c.active = ~mode[2];
    c.pos    = mode[1];
    c.indep  = ~mode[2] & mode[0];
    return c;
  endfunction
endpackage

// File: rtl/intr_edge_det.sv
module intr_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic active_i,
  input  logic pos_i,
  output logic edge_o
);
  localparam int unsigned ARM_W = SYNC_STAGES + 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [ARM_W-1:0]       arm_q;
  logic                   cur;

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      arm_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      prev_q <= cur;
      arm_q  <= {arm_q[ARM_W-2:0], 1'b1};
    end
  end

  // armed only once prev_q follows a real sample, so reset levels give no edge
  assign edge_o = arm_q[ARM_W-1] & active_i & (pos_i ? (cur & ~prev_q) : (~cur & prev_q));

  a_r5_edge_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o ##1 $stable(pos_i) |-> !edge_o);
  a_r6_inactive_no_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> !edge_o);
endmodule

// File: rtl/intr_flag_reg.sv
module intr_flag_reg #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_i) | set_i;
  end

  assign flag_o = flag_q;

  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |set_i |=> ((flag_o & $past(set_i)) == $past(set_i)));
  a_r2_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(clr_i & ~set_i) |=> ((flag_o & $past(clr_i & ~set_i)) == '0));
  a_r11_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_o & ~$past(flag_o) & ~$past(set_i)) == '0));
endmodule

// File: rtl/intr_en_reg.sv
module intr_en_reg #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic         dir_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] en_o
);
  logic [N-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (we_i) en_q <= dir_i ? (en_q | mask_i) : (en_q & ~mask_i);
  end

  assign en_o = en_q;

  a_r3_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && dir_i |=> ((en_o & $past(mask_i)) == $past(mask_i)));
  a_r3_clear_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !dir_i |=> ((en_o & $past(mask_i)) == '0));
  a_r3_zero_mask_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((en_o & ~($past(we_i) ? $past(mask_i) : '0)) ==
              ($past(en_o) & ~($past(we_i) ? $past(mask_i) : '0))));
endmodule

// File: rtl/intr_ctrl.sv
module intr_ctrl #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_addr_i,
  input  logic       reg_we_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic [7:0] pcr_i,
  input  logic       ca1_i,
  input  logic       ca2_i,
  input  logic       cb1_i,
  input  logic       cb2_i,
  input  logic       t1_set_i,
  input  logic       t2_set_i,
  input  logic       sr_set_i,
  input  logic       t1_clr_i,
  input  logic       t2_clr_i,
  input  logic       sr_acc_i,
  input  logic       ora_acc_i,
  input  logic       orb_acc_i,
  output logic       irq_no
);
  import intr_pkg::*;

  localparam int unsigned N = NUM_SRC;

  line_cfg_t [NUM_LINES-1:0] cfg;
  logic [NUM_LINES-1:0]      line_raw;
  logic [NUM_LINES-1:0]      line_edge;
  logic [N-1:0]              set_vec, clr_vec, wr_clr, side_clr;
  logic [N-1:0]              flag, en;
  logic                      any_irq;

  assign cfg[LN_CA1] = decode_primary(pcr_i[0]);
  assign cfg[LN_CA2] = decode_secondary(pcr_i[3:1]);
  assign cfg[LN_CB1] = decode_primary(pcr_i[4]);
  assign cfg[LN_CB2] = decode_secondary(pcr_i[7:5]);

  assign line_raw[LN_CA1] = ca1_i;
  assign line_raw[LN_CA2] = ca2_i;
  assign line_raw[LN_CB1] = cb1_i;
  assign line_raw[LN_CB2] = cb2_i;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    intr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .line_i   (line_raw[g]),
      .active_i (cfg[g].active),
      .pos_i    (cfg[g].pos),
      .edge_o   (line_edge[g])
    );
  end

  always_comb begin
    set_vec          = '0;
    set_vec[BIT_T1]  = t1_set_i;
    set_vec[BIT_T2]  = t2_set_i;
    set_vec[BIT_SR]  = sr_set_i;
    set_vec[BIT_CA1] = line_edge[LN_CA1];
    set_vec[BIT_CA2] = line_edge[LN_CA2];
    set_vec[BIT_CB1] = line_edge[LN_CB1];
    set_vec[BIT_CB2] = line_edge[LN_CB2];
  end

  always_comb begin
    side_clr          = '0;
    side_clr[BIT_T1]  = t1_clr_i;
    side_clr[BIT_T2]  = t2_clr_i;
    side_clr[BIT_SR]  = sr_acc_i;
    side_clr[BIT_CA1] = ora_acc_i;
    side_clr[BIT_CA2] = ora_acc_i & ~cfg[LN_CA2].indep;
    side_clr[BIT_CB1] = orb_acc_i;
    side_clr[BIT_CB2] = orb_acc_i & ~cfg[LN_CB2].indep;
  end

  assign wr_clr  = (reg_we_i && !reg_addr_i) ? reg_wdata_i[N-1:0] : '0;
  assign clr_vec = wr_clr | side_clr;

  intr_flag_reg #(.N(N)) u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .flag_o (flag)
  );

  intr_en_reg #(.N(N)) u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i & reg_addr_i),
    .dir_i  (reg_wdata_i[7]),
    .mask_i (reg_wdata_i[N-1:0]),
    .en_o   (en)
  );

  assign any_irq     = |(flag & en);
  assign irq_no      = ~any_irq;
  assign reg_rdata_o = reg_addr_i ? {1'b1, en} : {any_irq, flag};

  a_r8_ca2_indep_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ora_acc_i && cfg[LN_CA2].indep && flag[BIT_CA2] && !wr_clr[BIT_CA2] |=> flag[BIT_CA2]);
  a_r8_cb2_indep_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    orb_acc_i && cfg[LN_CB2].indep && flag[BIT_CB2] && !wr_clr[BIT_CB2] |=> flag[BIT_CB2]);
  a_r7_ora_clears_ca1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ora_acc_i && !line_edge[LN_CA1] |=> !flag[BIT_CA1]);
  a_r7_orb_clears_cb1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    orb_acc_i && !line_edge[LN_CB1] |=> !flag[BIT_CB1]);
endmodule

// File: tb/intr_ctrl_test.sv
module intr_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_addr_i = 1'b0, reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = '0, reg_rdata_o, pcr_i = 8'h55;
  logic       ca1_i = 1'b0, ca2_i = 1'b0, cb1_i = 1'b0, cb2_i = 1'b0;
  logic       t1_set_i = 1'b0, t2_set_i = 1'b0, sr_set_i = 1'b0;
  logic       t1_clr_i = 1'b0, t2_clr_i = 1'b0, sr_acc_i = 1'b0;
  logic       ora_acc_i = 1'b0, orb_acc_i = 1'b0;
  logic       irq_no;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  intr_ctrl uut (.*, .clk_i(clk));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    @(negedge clk);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  // line order {cb2, cb1, ca2, ca1}
  task automatic set_lines(logic [3:0] v);
    @(negedge clk);
    {cb2_i, cb1_i, ca2_i, ca1_i} = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse(int k);
    @(negedge clk);
    case (k)
      0: t1_set_i = 1'b1;  1: t2_set_i = 1'b1;  2: sr_set_i = 1'b1;
      3: t1_clr_i = 1'b1;  4: t2_clr_i = 1'b1;  5: sr_acc_i = 1'b1;
      6: ora_acc_i = 1'b1; default: orb_acc_i = 1'b1;
    endcase
    @(negedge clk);
    {t1_set_i, t2_set_i, sr_set_i, t1_clr_i, t2_clr_i, sr_acc_i, ora_acc_i, orb_acc_i} = '0;
  endtask

  // raise one flag bit, pcr assumed positive on all lines (0x55)
  task automatic raise_flag(int b);
    case (b)
      6: pulse(0);
      5: pulse(1);
      2: pulse(2);
      1: begin set_lines(4'b0001); set_lines(4'b0000); end
      0: begin set_lines(4'b0010); set_lines(4'b0000); end
      4: begin set_lines(4'b0100); set_lines(4'b0000); end
      default: begin set_lines(4'b1000); set_lines(4'b0000); end
    endcase
  endtask

  task automatic set_all();
    pulse(0); pulse(1); pulse(2);
    set_lines(4'b1111); set_lines(4'b0000);
  endtask

  initial begin
    logic [7:0] d;
    logic [3:0] lbit;
    int         fbit;
    ca1_i = 1'b1; // level held through reset must not flag
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    repeat (6) @(negedge clk);
    rd(0, d); check("R10 reset level no flag", d, 8'h00);
    rd(1, d); check("R3 enable reset", d, 8'h80);
    check("R4 irq idle", irq_no, 1'b1);
    set_lines(4'b0000); wr(0, 8'h7f);

    // R10 latency
    @(negedge clk) ca1_i = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    #1 check("R10 not yet", reg_rdata_o[1], 1'b0);
    @(posedge clk); @(negedge clk);
    #1 check("R10 flag after sync", reg_rdata_o[1], 1'b1);
    set_lines(4'b0000); wr(0, 8'h7f);

    // R1 / R11 layout
    for (int b = 0; b < 7; b++) begin
      raise_flag(b);
      rd(0, d); check("R1 R11 layout", d, 8'h01 << b);
      wr(0, 8'h7f);
    end

    // R5 primary lines
    for (int ln = 0; ln < 2; ln++)
      for (int pol = 0; pol < 2; pol++)
        for (int dir = 0; dir < 2; dir++) begin
          pcr_i = (ln == 0) ? 8'(pol) : 8'(pol << 4);
          lbit  = (ln == 0) ? 4'b0001 : 4'b0100;
          fbit  = (ln == 0) ? 1 : 4;
          set_lines(dir ? 4'b0000 : lbit); wr(0, 8'h7f);
          set_lines(dir ? lbit : 4'b0000);
          rd(0, d); check("R5 primary polarity", d[fbit], 1'(pol == dir));
          set_lines(4'b0000); wr(0, 8'h7f);
        end

    // R6 secondary modes
    for (int ln = 0; ln < 2; ln++)
      for (int m = 0; m < 8; m++)
        for (int dir = 0; dir < 2; dir++) begin
          pcr_i = (ln == 0) ? 8'(m << 1) : 8'(m << 5);
          lbit  = (ln == 0) ? 4'b0010 : 4'b1000;
          fbit  = (ln == 0) ? 0 : 3;
          set_lines(dir ? 4'b0000 : lbit); wr(0, 8'h7f);
          set_lines(dir ? lbit : 4'b0000);
          rd(0, d);
          check("R6 secondary mode", d[fbit], 1'((m < 4) && (((m >> 1) & 1) == dir)));
          set_lines(4'b0000); wr(0, 8'h7f);
        end

    // R2 write-one clear
    pcr_i = 8'h55;
    set_all(); rd(0, d); check("R2 all set", d, 8'h7f);
    wr(0, 8'h2a); rd(0, d); check("R2 partial clear", d, 8'h55);
    wr(0, 8'h00); rd(0, d); check("R2 zero write", d, 8'h55);
    wr(0, 8'hff); rd(0, d); check("R2 full clear", d, 8'h00);

    // R7 access clears
    set_all();
    pulse(6); rd(0, d); check("R7 ora clear", d, 8'h7c);
    pulse(7); rd(0, d); check("R7 orb clear", d, 8'h64);
    pulse(5); rd(0, d); check("R7 sr clear", d, 8'h60);
    pulse(3); rd(0, d); check("R7 t1 clear", d, 8'h20);
    pulse(4); rd(0, d); check("R7 t2 clear", d, 8'h00);

    // R8 independent secondary lines
    pcr_i = 8'h77;
    set_all(); rd(0, d); check("R8 all set", d, 8'h7f);
    pulse(6); rd(0, d); check("R8 ora keeps ca2", d, 8'h7d);
    pulse(7); rd(0, d); check("R8 orb keeps cb2", d, 8'h6d);
    wr(0, 8'h09); rd(0, d); check("R8 write clears", d, 8'h64);
    wr(0, 8'h7f); pcr_i = 8'h55;

    // R9 set wins
    @(negedge clk);
    t1_set_i = 1'b1; reg_addr_i = 1'b0; reg_wdata_i = 8'h40; reg_we_i = 1'b1;
    @(negedge clk);
    t1_set_i = 1'b0; reg_we_i = 1'b0;
    rd(0, d); check("R9 set over clear", d, 8'h40);

    // R3 enable protocol and R1 bit 7
    wr(1, 8'hd5); rd(1, d); check("R3 set", d, 8'hd5);
    rd(0, d); check("R1 bit7 on", d, 8'hc0);
    wr(1, 8'h45); rd(1, d); check("R3 clear", d, 8'h90);
    rd(0, d); check("R1 bit7 off", d, 8'h40);
    wr(1, 8'h00); rd(1, d); check("R3 empty clear", d, 8'h90);
    wr(1, 8'h80); rd(1, d); check("R3 empty set", d, 8'h90);
    wr(1, 8'h7f); wr(0, 8'h7f);

    // R4 flag x enable sweep
    for (int i = 0; i < 7; i++) begin
      raise_flag(i);
      for (int j = 0; j < 7; j++) begin
        wr(1, 8'h7f); wr(1, 8'h80 | (8'h01 << j));
        #1 check("R4 irq", irq_no, 1'(i != j));
      end
      wr(1, 8'h7f); wr(0, 8'h7f);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule